// File: doc/BRIEF.md
# Pixel Event Readout Framer

This block frames the readout of one trigger for a pixel front-end chip. A start strobe captures the bunch-crossing number, event number and chip address, and the block then sends a 32-bit header word. Hit records of 30 bits arrive on a valid/ready stream: a 24-bit pixel address, a 5-bit ADC value and a 1-bit flag. Each record goes out as a 32-bit word. An end strobe closes the event, and a 32-bit trailer follows. The trailer holds the number of hits sent, a 12-bit check value and error flags.

The control is a four-state machine. The states are ST_IDLE, ST_HEAD (the header word is offered), ST_BODY (hits pass through) and ST_TAIL (the trailer word is offered). The transitions are named as follows:
- start: ST_IDLE to ST_HEAD when the start strobe is seen.
- head_taken: ST_HEAD to ST_BODY when the header is accepted.
- close: ST_BODY to ST_TAIL when the end strobe is seen in ST_BODY, or was seen earlier in ST_HEAD.
- tail_taken: ST_TAIL to ST_IDLE when the trailer is accepted.

The number of hits per event is capped by the parameter MAX_HITS, which defaults to 1023. Hits beyond the cap are taken from the input and discarded.

Top module: `pix_event_framer`

## Requirements
- R1: The first cycle after a start strobe is sampled in ST_IDLE offers the header word. Its layout is {bx[31:20], event id[19:8], chip address[7:4], status[3:0]=0}. The fields are the values captured with the start strobe.
- R2: Each accepted hit is sent as one word {2'b00 at [31:30], address[29:6], ADC[5:1], flag[0]}. Hits go out in arrival order, right after the header.
- R3: The trailer word {hit count[31:16], check[15:4], error[3:0]} is offered in the cycle after the end strobe is sampled in ST_BODY. It is the last word of the event.
- R4: The check value is the XOR, over all hits sent, of rec[11:0] ^ rec[23:12] ^ {6'b0, rec[29:24]}. Here rec is the 30-bit record {address, ADC, flag}.
- R5: An event with no hits sends exactly a header and a trailer with count 0, check 0 and error 0. This holds even if the end strobe arrives while the header is still waiting.
- R6: Hits after MAX_HITS hits in one event are accepted (hit_ready high) and dropped, producing no output word. In the trailer the count stays at MAX_HITS and error bit 0 is set. Exactly MAX_HITS hits leaves error bit 0 clear.
- R7: While out_valid is high and out_ready is low, the next cycle keeps out_valid high with an unchanged word. No word is lost or repeated.
- R8: Outside an event, out_valid and hit_ready are low. A start strobe during an event is ignored and creates no extra words.
- R9: hit_ready stays low while the header word is offered.
- R10: During reset, out_valid and hit_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_start | input | 1 | Event start strobe |
| evt_bx | input | 12 | Bunch-crossing number for the header |
| evt_id | input | 12 | Event number for the header |
| evt_chip | input | 4 | Chip address for the header |
| evt_end | input | 1 | End-of-event strobe |
| hit_valid | input | 1 | Hit record valid |
| hit_ready | output | 1 | Hit record accepted |
| hit_addr | input | 24 | Pixel address |
| hit_adc | input | 5 | ADC value |
| hit_flag | input | 1 | Hit flag |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink ready for the output word |
| out_data | output | 32 | Output word |

## Verification
The header becomes valid one cycle after the start strobe is sampled. Hit words are combinational from the hit input and due in the same cycle. The trailer is due one cycle after the end strobe meets ST_BODY. The bench drives inputs on the falling edge and samples one nanosecond later, so each result is read in the cycle in which it is due. Header and trailer timing are each checked at exactly that sample. A monitor captures every handshaken word in that same sample window, checks that stalled words hold, and after each event waits several idle cycles to prove that no extra word appears.

// File: rtl/pef_pkg.sv
package pef_pkg;
    localparam int BX_W   = 12;
    localparam int EVID_W = 12;
    localparam int CHIP_W = 4;
    localparam int STAT_W = 4;
    localparam int ADDR_W = 24;
    localparam int ADC_W  = 5;
    localparam int REC_W  = ADDR_W + ADC_W + 1;
    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam int CSUM_W = 12;
    localparam int ERR_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HEAD,
        ST_BODY,
        ST_TAIL
    } pef_state_e;

    // Fold a record into CSUM_W bits by XOR of consecutive slices.
    function automatic logic [CSUM_W-1:0] fold_rec(input logic [REC_W-1:0] r);
        logic [CSUM_W-1:0] res;
        res = '0;
        for (int k = 0; k < REC_W; k++) begin
            res[k % CSUM_W] = res[k % CSUM_W] ^ r[k];
        end
        return res;
    endfunction
endpackage

// File: rtl/pef_ctrl.sv
module pef_ctrl
    import pef_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt_start,
    input  logic       evt_end,
    input  logic       hit_valid,
    input  logic       out_ready,
    input  logic       hit_full,
    output pef_state_e state_q,
    output logic       out_valid,
    output logic       hit_ready,
    output logic       hdr_load,
    output logic       hit_take,
    output logic       hit_drop
);
    pef_state_e state_d;
    logic       end_pend_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            end_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HEAD && evt_end)
                end_pend_q <= 1'b1;
            else if (state_q == ST_BODY)
                end_pend_q <= 1'b0;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (evt_start)              state_d = ST_HEAD;
            ST_HEAD: if (out_ready)              state_d = ST_BODY;
            ST_BODY: if (evt_end || end_pend_q)  state_d = ST_TAIL;
            ST_TAIL: if (out_ready)              state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        hit_ready = 1'b0;
        hdr_load  = 1'b0;
        hit_take  = 1'b0;
        hit_drop  = 1'b0;
        unique case (state_q)
            ST_IDLE: hdr_load = evt_start;
            ST_HEAD: out_valid = 1'b1;
            ST_BODY: begin
                if (hit_full) begin
                    hit_ready = 1'b1;
                    hit_drop  = hit_valid;
                end else begin
                    out_valid = hit_valid;
                    hit_ready = out_ready;
                    hit_take  = hit_valid && out_ready;
                end
            end
            ST_TAIL: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/pef_accum.sv
module pef_accum
    import pef_pkg::*;
#(
    parameter int MAX_HITS = 1023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_load,
    input  logic [BX_W-1:0]   evt_bx,
    input  logic [EVID_W-1:0] evt_id,
    input  logic [CHIP_W-1:0] evt_chip,
    input  logic              hit_take,
    input  logic              hit_drop,
    input  logic [REC_W-1:0]  hit_rec,
    output logic [WORD_W-1:0] hdr_word,
    output logic [WORD_W-1:0] trl_word,
    output logic              hit_full,
    output logic [CNT_W-1:0]  hit_cnt
);
    logic [BX_W-1:0]   bx_q;
    logic [EVID_W-1:0] id_q;
    logic [CHIP_W-1:0] chip_q;
    logic [CSUM_W-1:0] csum_q;
    logic              ovf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bx_q    <= '0;
            id_q    <= '0;
            chip_q  <= '0;
            hit_cnt <= '0;
            csum_q  <= '0;
            ovf_q   <= 1'b0;
        end else if (hdr_load) begin
            bx_q    <= evt_bx;
            id_q    <= evt_id;
            chip_q  <= evt_chip;
            hit_cnt <= '0;
            csum_q  <= '0;
            ovf_q   <= 1'b0;
        end else begin
            if (hit_take) begin
                hit_cnt <= hit_cnt + 1'b1;
                csum_q  <= csum_q ^ fold_rec(hit_rec);
            end
            if (hit_drop)
                ovf_q <= 1'b1;
        end
    end

    assign hit_full = (hit_cnt == CNT_W'(MAX_HITS));
    assign hdr_word = {bx_q, id_q, chip_q, {STAT_W{1'b0}}};
    assign trl_word = {hit_cnt, csum_q, {(ERR_W-1){1'b0}}, ovf_q};
endmodule

// File: rtl/pef_pack.sv
module pef_pack
    import pef_pkg::*;
(
    input  pef_state_e        state_q,
    input  logic [WORD_W-1:0] hdr_word,
    input  logic [WORD_W-1:0] trl_word,
    input  logic [REC_W-1:0]  hit_rec,
    output logic [WORD_W-1:0] out_data
);
    always_comb begin
        unique case (state_q)
            ST_HEAD: out_data = hdr_word;
            ST_BODY: out_data = {{(WORD_W-REC_W){1'b0}}, hit_rec};
            ST_TAIL: out_data = trl_word;
            default: out_data = '0;
        endcase
    end
endmodule

// File: rtl/pix_event_framer.sv
module pix_event_framer
    import pef_pkg::*;
#(
    parameter int MAX_HITS = 1023
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        evt_start,
    input  logic [11:0] evt_bx,
    input  logic [11:0] evt_id,
    input  logic [3:0]  evt_chip,
    input  logic        evt_end,
    input  logic        hit_valid,
    output logic        hit_ready,
    input  logic [23:0] hit_addr,
    input  logic [4:0]  hit_adc,
    input  logic        hit_flag,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_data
);
    pef_state_e        state_q;
    logic              hdr_load;
    logic              hit_take;
    logic              hit_drop;
    logic              hit_full;
    logic [CNT_W-1:0]  hit_cnt;
    logic [WORD_W-1:0] hdr_word;
    logic [WORD_W-1:0] trl_word;
    logic [REC_W-1:0]  hit_rec;

    assign hit_rec = {hit_addr, hit_adc, hit_flag};

    pef_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_start (evt_start),
        .evt_end   (evt_end),
        .hit_valid (hit_valid),
        .out_ready (out_ready),
        .hit_full  (hit_full),
        .state_q   (state_q),
        .out_valid (out_valid),
        .hit_ready (hit_ready),
        .hdr_load  (hdr_load),
        .hit_take  (hit_take),
        .hit_drop  (hit_drop)
    );

    pef_accum #(.MAX_HITS(MAX_HITS)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .hdr_load (hdr_load),
        .evt_bx   (evt_bx),
        .evt_id   (evt_id),
        .evt_chip (evt_chip),
        .hit_take (hit_take),
        .hit_drop (hit_drop),
        .hit_rec  (hit_rec),
        .hdr_word (hdr_word),
        .trl_word (trl_word),
        .hit_full (hit_full),
        .hit_cnt  (hit_cnt)
    );

    pef_pack u_pack (
        .state_q  (state_q),
        .hdr_word (hdr_word),
        .trl_word (trl_word),
        .hit_rec  (hit_rec),
        .out_data (out_data)
    );
endmodule

// File: rtl/pef_checker.sv
module pef_checker
    import pef_pkg::*;
#(
    parameter int MAX_HITS = 1023
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_end,
    input logic             hit_valid,
    input logic             hit_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_data,
    input pef_state_e       state_q,
    input logic             hit_full,
    input logic [CNT_W-1:0] hit_cnt
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !out_valid && !hit_ready); // R8
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && state_q != ST_BODY |=> out_valid && $stable(out_data)); // R7
    AST_HEAD_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HEAD |-> !hit_ready); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BODY && hit_full && hit_valid |-> hit_ready && !out_valid); // R6
    AST_PASS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BODY && !hit_full |-> out_valid == hit_valid); // R2
    AST_TAIL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_BODY && evt_end |=> state_q == ST_TAIL && out_valid); // R3
    AST_EMPTY_START: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HEAD |-> hit_cnt == '0); // R5
    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cnt <= CNT_W'(MAX_HITS)); // R6
endmodule

bind pix_event_framer pef_checker #(.MAX_HITS(MAX_HITS)) u_chk (.*);

// File: tb/tb_pix_event_framer.sv
module tb_pix_event_framer;
    localparam int MAXH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_start = 1'b0;
    logic [11:0] evt_bx = '0;
    logic [11:0] evt_id = '0;
    logic [3:0]  evt_chip = '0;
    logic        evt_end = 1'b0;
    logic        hit_valid = 1'b0;
    logic        hit_ready;
    logic [23:0] hit_addr = '0;
    logic [4:0]  hit_adc = '0;
    logic        hit_flag = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] cap [0:63];
    int cap_n = 0;
    logic prev_stall = 1'b0;
    logic [31:0] prev_word = '0;

    pix_event_framer #(.MAX_HITS(MAXH)) dut (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: sample 1ns after the falling edge, before the next rising edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (prev_stall)
                chk(out_valid && out_data == prev_word, "R7 stalled word held", out_data, prev_word);
            prev_stall = out_valid && !out_ready;
            prev_word  = out_data;
            if (out_valid && out_ready && cap_n < 64) begin
                cap[cap_n] = out_data;
                cap_n++;
            end
        end
    end

    function automatic logic [29:0] gen(input int i, input int s);
        logic [23:0] a;
        logic [4:0]  d;
        a = 24'(i * 24'h010305 + s * 24'h091F00 + 7);
        d = 5'(i * 7 + s);
        return {a, d, 1'(i ^ s)};
    endfunction

    function automatic logic rdy(input bit stall);
        return stall ? ((cyc % 3) != 1) : 1'b1;
    endfunction

    task automatic run_event(input int bx, input int id, input int chip, input int n,
                             input bit stall, input bit poke);
        logic [31:0] exp [0:63];
        logic [11:0] csum;
        int nsent;
        int exp_n;
        int i;
        int tmo;
        bit acc;
        logic [29:0] r;
        nsent = (n > MAXH) ? MAXH : n;
        csum = '0;
        exp[0] = {12'(bx), 12'(id), 4'(chip), 4'h0};
        for (int k = 0; k < nsent; k++) begin
            r = gen(k, bx);
            exp[k+1] = {2'b00, r};
            csum = csum ^ r[11:0] ^ r[23:12] ^ {6'b0, r[29:24]};
        end
        exp[nsent+1] = {16'(nsent), csum, 3'b000, 1'(n > MAXH)};
        exp_n = nsent + 2;
        cap_n = 0;

        @(negedge clk);
        evt_start = 1'b1; evt_bx = 12'(bx); evt_id = 12'(id); evt_chip = 4'(chip);
        out_ready = 1'b1;
        @(negedge clk);
        evt_start = 1'b0; evt_bx = ~evt_bx; evt_id = ~evt_id; evt_chip = ~evt_chip;
        out_ready = rdy(stall);
        #1;
        chk(out_valid && out_data == exp[0], "R1 header one cycle after start", out_data, exp[0]);
        chk(!hit_ready, "R9 no hit taken during header", 32'(hit_ready), 0);
        i = 0;
        while (i < n) begin
            if (i > 0 || !(n > 0)) begin
                @(negedge clk);
            end
            r = gen(i, bx);
            {hit_addr, hit_adc, hit_flag} = r;
            hit_valid = 1'b1;
            out_ready = rdy(stall);
            evt_start = poke && (i == 1);
            #1;
            acc = hit_valid && hit_ready;
            if (acc) i++;
            else begin
                @(negedge clk);
                while (1) begin
                    out_ready = rdy(stall);
                    evt_start = 1'b0;
                    #1;
                    if (hit_ready) break;
                    @(negedge clk);
                end
                i++;
            end
        end
        @(negedge clk);
        hit_valid = 1'b0; evt_start = 1'b0;
        evt_end = 1'b1;
        out_ready = rdy(stall);
        @(negedge clk);
        evt_end = 1'b0;
        out_ready = rdy(stall);
        #1;
        if (n > 0)
            chk(out_valid && out_data == exp[exp_n-1], "R3 trailer one cycle after end", out_data, exp[exp_n-1]);
        tmo = 0;
        while (cap_n < exp_n && tmo < 60) begin
            @(negedge clk);
            out_ready = rdy(stall);
            tmo++;
        end
        @(negedge clk);
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk(cap_n == exp_n, "R8 word count, no extra words", 32'(cap_n), 32'(exp_n));
        chk(!out_valid && !hit_ready, "R8 quiet after event", {30'b0, out_valid, hit_ready}, 0);
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            if (k == 0)
                chk(cap[k] == exp[k], "R1 header word", cap[k], exp[k]);
            else if (k == exp_n - 1) begin
                if (n == 0)
                    chk(cap[k] == exp[k], "R5 empty-event trailer", cap[k], exp[k]);
                else if (n > MAXH)
                    chk(cap[k] == exp[k], "R6 overflow trailer", cap[k], exp[k]);
                else
                    chk(cap[k] == exp[k], "R3 R4 trailer count and check", cap[k], exp[k]);
            end else
                chk(cap[k] == exp[k], "R2 R9 hit word in order", cap[k], exp[k]);
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid && !hit_ready, "R10 reset outputs low", {30'b0, out_valid, hit_ready}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(!out_valid && !hit_ready, "R8 idle after reset", {30'b0, out_valid, hit_ready}, 0);
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n <= MAXH + 2; n++) begin
                run_event(100 + n * 37 + s * 5, 900 + n, n + s, n, s[0], 1'b0);
            end
        end
        run_event(3001, 77, 9, 3, 1'b0, 1'b1);
        run_event(4000, 12, 3, 0, 1'b1, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule